// File: doc/BRIEF.md
# Clock-Status Edge Event Capture

This block watches four asynchronous level status signals from a redundant reference-clock unit: primary loss-of-signal, secondary loss-of-signal, PLL holdover and PLL unlock. Each signal passes through a two-stage synchronizer. A rise and a fall of each synchronized level each set their own sticky bit in an 8-bit cause byte. A host reads that byte over a small byte-wide read port, and the read clears it.

The block also presents a live alarm byte that carries the synchronized levels. It presents an identification byte whose low nibble gives the interrupt line number. It drives one level interrupt that stays high while any cause bit is set. A host can discard stale events by reading the cause byte once before it enables the interrupt.

Top module: `clk_evt_capture`

## Requirements
- R1: After reset, the cause byte reads 0x00 and irq_o is low.
- R2: Channel c (0 primary loss, 1 secondary loss, 2 holdover, 3 unlock) sets cause bit 2c when its level goes from 0 to 1. It sets cause bit 2c+1 when its level goes from 1 to 0.
- R3: A cause bit first reads as set, and irq_o first goes high, after the third rising clock edge that follows the input change. The bit then stays set until it is cleared.
- R4: A read with rd_i high at offset 6 returns the cause byte as it was before that edge. The cause byte is zero after the edge.
- R5: An event detected on the same edge as a clearing read is kept in the cause byte.
- R6: irq_o is high exactly while any cause bit is set. It drops in the cycle after a clearing read when no new event arrives.
- R7: Offset 2 returns the synchronized levels in its upper nibble, with bit 7 primary loss, bit 6 secondary loss, bit 5 holdover and bit 4 unlock. Its lower nibble reads 0. Its value follows an input change after two rising edges.
- R8: Offset 7 returns IRQ_LINE in bits 3:0 with the upper bits 0. Other unused offsets return 0. A read at any offset other than 6 leaves the cause byte unchanged.
- R9: Levels that are already high when reset is released latch no event.
- R10: Events on different channels or at different times accumulate by OR until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| status_i | input | 4 | Asynchronous levels: [0] primary loss, [1] secondary loss, [2] holdover, [3] unlock |
| addr_i | input | 3 | Byte offset in the read window |
| rd_i | input | 1 | Read strobe; at offset 6 it clears the cause byte |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt, high while any cause bit is set |

## Verification
An input change reaches the alarm byte after two rising edges. It reaches the cause byte and irq_o after three edges. A clearing read takes effect on the edge where rd_i is sampled, so irq_o falls one cycle later. The bench changes inputs on the falling edge and runs a cycle-accurate reference model on the rising edge. It compares rdata_o and irq_o on every falling edge, half a cycle after the edge that updated them. Directed cases test the three-edge latency explicitly: the bench checks that irq_o is still low after two edges and high after the third. They also place a new event on the same edge as a clearing read.

// File: rtl/clk_evt_pkg.sv
package clk_evt_pkg;
  localparam int NCH       = 4;
  localparam int AW        = 3;
  localparam int DW        = 8;
  localparam int SYNC_STG  = 2;
  localparam logic [AW-1:0] OFS_ALARM = 3'd2;
  localparam logic [AW-1:0] OFS_CAUSE = 3'd6;
  localparam logic [AW-1:0] OFS_ID    = 3'd7;

  typedef enum int {CH_PRI_LOS = 0, CH_SEC_LOS = 1, CH_HOLD = 2, CH_UNLOCK = 3} chan_e;
endpackage

// File: rtl/cevt_sync.sv
module cevt_sync #(
  parameter int W   = 4,
  parameter int STG = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STG-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STG; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STG-1];
endmodule

// File: rtl/cevt_edge.sv
module cevt_edge #(
  parameter int NCH   = 4,
  parameter int PRIME = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   lvl_i,
  output logic [2*NCH-1:0] evt_o
);
  localparam int CW = $clog2(PRIME + 1);

  logic [CW-1:0]  cnt_q;
  logic [NCH-1:0] hist_q;
  logic           primed;

  assign primed = (cnt_q == CW'(PRIME));

  // history tracks the levels during priming, so the first comparison has no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hist_q <= '0;
    end else begin
      hist_q <= lvl_i;
      if (!primed) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign evt_o[2*c]   = primed &  lvl_i[c] & ~hist_q[c];
    assign evt_o[2*c+1] = primed & ~lvl_i[c] &  hist_q[c];
  end
endmodule

// File: rtl/cevt_cause.sv
module cevt_cause #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_i,
  output logic [DW-1:0] cause_o
);
  logic [DW-1:0] cause_q;

  // new events override the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (clr_i ? '0 : cause_q) | evt_i;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/cevt_rdmux.sv
module cevt_rdmux
  import clk_evt_pkg::*;
#(
  parameter int IRQ_LINE = 5
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [NCH-1:0] lvl_i,
  input  logic [DW-1:0]  cause_i,
  output logic [DW-1:0]  rdata_o
);
  localparam logic [3:0] ID_NIB = 4'(IRQ_LINE);

  logic [3:0] alarm_nib;
  assign alarm_nib = {lvl_i[CH_PRI_LOS], lvl_i[CH_SEC_LOS], lvl_i[CH_HOLD], lvl_i[CH_UNLOCK]};

  always_comb begin
    case (addr_i)
      OFS_ALARM: rdata_o = {alarm_nib, 4'h0};
      OFS_CAUSE: rdata_o = cause_i;
      OFS_ID:    rdata_o = {4'h0, ID_NIB};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/clk_evt_capture.sv
module clk_evt_capture
  import clk_evt_pkg::*;
#(
  parameter int IRQ_LINE = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    status_i,
  input  logic [2:0]    addr_i,
  input  logic          rd_i,
  output logic [7:0]    rdata_o,
  output logic          irq_o
);
  localparam int PRIME = SYNC_STG + 1;

  logic [NCH-1:0]   lvl;
  logic [2*NCH-1:0] evt;
  logic [DW-1:0]    cause_q;
  logic             clr;

  assign clr = rd_i & (addr_i == OFS_CAUSE);

  cevt_sync #(.W(NCH), .STG(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(status_i), .q_o(lvl)
  );

  cevt_edge #(.NCH(NCH), .PRIME(PRIME)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .evt_o(evt)
  );

  cevt_cause #(.DW(DW)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .clr_i(clr), .cause_o(cause_q)
  );

  cevt_rdmux #(.IRQ_LINE(IRQ_LINE)) u_rdmux (
    .addr_i(addr_i), .lvl_i(lvl), .cause_i(cause_q), .rdata_o(rdata_o)
  );

  assign irq_o = |cause_q;
endmodule

// File: rtl/clk_evt_capture_chk.sv
module clk_evt_capture_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] evt_i,
  input logic [7:0] cause_i,
  input logic       clr_i,
  input logic       irq_i
);
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((cause_i & $past(cause_i)) == $past(cause_i)));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cause_i == $past(evt_i)));

  p_evt_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != 8'h00) |=> ((cause_i & $past(evt_i)) == $past(evt_i)));

  p_irq_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == 8'h00) |=> !irq_i);

  p_irq_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ($past(evt_i) != 8'h00));

  for (genvar c = 0; c < 4; c++) begin : g_pair
    p_pair_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(evt_i[2*c +: 2]));
  end
endmodule

bind clk_evt_capture clk_evt_capture_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .cause_i(cause_q),
  .clr_i(clr), .irq_i(irq_o)
);

// File: tb/tb_clk_evt_capture.sv
module tb_clk_evt_capture;
  localparam int PERIOD   = 10;
  localparam int IRQ_LINE = 5;
  localparam int N_RAND   = 4000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] status_i = 4'h0;
  logic [2:0] addr_i = 3'd0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;

  clk_evt_capture #(.IRQ_LINE(IRQ_LINE)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_i), .addr_i(addr_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  // reference model built from the requirements
  logic [3:0] m_s1, m_s2, m_h;
  logic [1:0] m_cnt;
  logic [7:0] m_cause;

  function automatic logic [7:0] m_evt(logic [3:0] lvl, logic [3:0] h, logic [1:0] cnt);
    logic [7:0] e = '0;
    if (cnt == 2'd3)
      for (int c = 0; c < 4; c++) begin
        e[2*c]   = lvl[c] & ~h[c];
        e[2*c+1] = ~lvl[c] & h[c];
      end
    return e;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= '0; m_s2 <= '0; m_h <= '0; m_cnt <= '0; m_cause <= '0;
    end else begin
      m_cause <= ((rd_i && addr_i == 3'd6) ? 8'h00 : m_cause) | m_evt(m_s2, m_h, m_cnt);
      m_h  <= m_s2;
      m_s2 <= m_s1;
      m_s1 <= status_i;
      if (m_cnt != 2'd3) m_cnt <= m_cnt + 2'd1;
    end
  end

  function automatic logic [7:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd2:    return {m_s2[0], m_s2[1], m_s2[2], m_s2[3], 4'h0};
      3'd6:    return m_cause;
      3'd7:    return 8'(IRQ_LINE);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_model(string req);
    chk({req, " irq"}, {7'd0, irq_o}, {7'd0, m_cause != 8'h00});
    chk({req, " rdata"}, rdata_o, exp_rdata(addr_i));
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    status_i = 4'hF;           // R9: levels high through reset
    addr_i = 3'd6;
    cyc(3);
    rst_ni = 1'b1;
    chk("R1 cause after reset", rdata_o, 8'h00);
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    cyc(8);
    chk("R9 no startup event", rdata_o, 8'h00);
    chk("R9 irq quiet", {7'd0, irq_o}, 8'h00);
    addr_i = 3'd2; #1;
    chk("R7 alarm all high", rdata_o, 8'hF0);
    addr_i = 3'd7; #1;
    chk("R8 id byte", rdata_o, 8'(IRQ_LINE));
    addr_i = 3'd3; #1;
    chk("R8 unused offset", rdata_o, 8'h00);

    // all levels fall: R2 odd bits, R3 latency
    addr_i = 3'd6;
    status_i = 4'h0;
    cyc(2);
    chk("R3 not yet after two edges", {7'd0, irq_o}, 8'h00);
    addr_i = 3'd2; #1;
    chk("R7 alarm after two edges", rdata_o, 8'h00);
    addr_i = 3'd6;
    cyc(1);
    chk("R3 irq after third edge", {7'd0, irq_o}, 8'h01);
    chk("R2 fall bits", rdata_o, 8'hAA);
    cyc(5);
    chk("R3 sticky", rdata_o, 8'hAA);

    // clearing read
    rd_i = 1'b1;
    cyc(1);
    rd_i = 1'b0;
    chk("R4 cleared", rdata_o, 8'h00);
    chk("R6 irq drops", {7'd0, irq_o}, 8'h00);

    // R10 accumulation, R2 rise bits
    status_i[0] = 1'b1;
    cyc(4);
    chk("R2 primary rise", rdata_o, 8'h01);
    status_i[2] = 1'b1;
    cyc(4);
    chk("R10 accumulate", rdata_o, 8'h11);

    // R8 read elsewhere does not clear
    addr_i = 3'd2; rd_i = 1'b1;
    cyc(1);
    rd_i = 1'b0; addr_i = 3'd6; #1;
    chk("R8 no clear off-offset", rdata_o, 8'h11);

    // R5 event on clearing edge
    status_i[3] = 1'b1;
    cyc(2);
    rd_i = 1'b1; #1;
    chk("R4 read returns pre-clear", rdata_o, 8'h11);
    cyc(1);
    rd_i = 1'b0;
    chk("R5 new event kept", rdata_o, 8'h40);
    chk("R6 irq stays high", {7'd0, irq_o}, 8'h01);

    // random phase against the model
    for (int i = 0; i < N_RAND; i++) begin
      chk_model("R2/R3/R4/R6/R7 random");
      if ($urandom_range(7) == 0) status_i[$urandom_range(3)] ^= 1'b1;
      rd_i = ($urandom_range(3) == 0);
      case ($urandom_range(3))
        0: addr_i = 3'd2;
        1: addr_i = 3'd6;
        2: addr_i = 3'd7;
        default: addr_i = 3'($urandom_range(7));
      endcase
      #1;
      chk("R8 rdata comb", rdata_o, exp_rdata(addr_i));
      cyc(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule